// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a first-in first-out buffer of sixteen 4-bit words, built as a chain of stages rather than a memory with read and write pointers. Every stage carries a marker bit showing whether it holds a word. A vacant stage pulls the word from an occupied neighbour on its input side, one stage per clock. Words therefore fall toward the output end, and vacancies rise toward the input end. The two flags are taken straight from the markers of the first and last stages.

A producer presents a word and raises the shift-in strobe. A consumer reads the word at the output and completes a read by lowering the shift-out strobe. Both strobes also work as held levels. Holding shift-in high waits for a free slot. Holding shift-out high takes the next word as soon as it arrives. The block runs on one clock. It has an active-low master reset and an active-low output enable that floats the data outputs.

Top module: `bubble_fifo`

## Requirements
- R1: While rst_ni is low, all markers clear, in_ready_o is 1, out_ready_o is 0 and no word moves. data_o keeps the word it showed before reset.
- R2: Words leave in the order they were loaded. A word loaded into an empty FIFO by a one-cycle shift-in pulse raises out_ready_o after the 15th rising clock edge following its capture edge.
- R3: in_ready_o is the inverse of the input-stage marker. It is low in the cycle after a capture and high again one cycle later when space remains. With 16 words stored it stays low.
- R4: While shift_in_i stays high after a capture, the captured word does not leave the input stage. It moves on the first clock edge that samples shift_in_i low.
- R5: A shift-in whose rising edge finds the input stage occupied, and which is released before a slot frees, is dropped. The stored words are unchanged and no extra word appears.
- R6: A falling edge of shift_out_i while out_ready_o is 1 removes the output word, and out_ready_o drops for exactly one cycle when another word waits behind it. When no word remains, out_ready_o stays low and data_o keeps the last word removed. A falling edge with the FIFO empty has no effect.
- R7: If shift_in_i is already high when reset is released, the word on data_i is captured on the first clock edge after release.
- R8: If shift_in_i is held high while the FIFO is full, the pending word is captured as soon as a vacancy reaches the input stage. in_ready_o is then high for exactly one cycle.
- R9: If shift_out_i is held high while the FIFO is empty, an arriving word raises out_ready_o for exactly one cycle and is then removed. No further word is removed until shift_out_i has been low. The falling edge that ends that high period removes nothing.
- R10: With oe_ni high the data outputs are released to high impedance, so the stored word is not presented. With oe_ni low the output-stage word is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| data_i | input | 4 | Word to load |
| shift_in_i | input | 1 | Load strobe; rising edge or held level |
| shift_out_i | input | 1 | Read strobe; falling edge completes a read |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 4 | Output-stage word, tri-stated when disabled |
| in_ready_o | output | 1 | Input stage vacant |
| out_ready_o | output | 1 | Valid word on data_o |

## Verification
The fall-through path is exercised in several ways. A single word passes through an empty chain to check the exact 15-edge latency. A strobe held high pins a word in the input stage, which separates the level-sensitive release from the edge-triggered capture. Full-depth fill and drain rounds use distinct data patterns to expose ordering or lost-word faults, and an extra pulse into a full chain shows whether overflow is dropped. The held-strobe cases are run separately so that they are told apart from ordinary pulses by counting the cycles each flag stays high: an auto-load behind a full chain, and an auto-read into an empty one.

// File: rtl/bff_pkg.sv
package bff_pkg;
  localparam int unsigned BFF_WIDTH = 4;
  localparam int unsigned BFF_DEPTH = 16;
endpackage

// File: rtl/bff_in_ctrl.sv
module bff_in_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic si_i,
  input  logic load_i,
  input  logic in_full_i,
  output logic req_o,
  output logic block_o
);
  logic si_q, armed_q, hold_q;
  logic rise;

  assign rise    = si_i & ~si_q;
  assign req_o   = si_i & (armed_q | rise);
  // captured word stays in stage 0 until shift-in drops
  assign block_o = hold_q & si_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si_q    <= 1'b0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      si_q    <= si_i;
      armed_q <= si_i & ~load_i & (armed_q | rise);
      hold_q  <= si_i & (hold_q | load_i);
    end
  end

  AST_INPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && si_i && in_full_i |=> in_full_i); // R4

endmodule

// File: rtl/bff_out_ctrl.sv
module bff_out_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic so_i,
  input  logic last_full_i,
  output logic pop_o
);
  logic so_q, wait_q, used_q;
  logic fall;

  assign fall  = ~so_i & so_q;
  assign pop_o = last_full_i & ((fall & ~used_q) | (so_i & wait_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_q   <= 1'b0;
      wait_q <= 1'b0;
      used_q <= 1'b0;
    end else begin
      so_q   <= so_i;
      used_q <= so_i & (used_q | pop_o);
      wait_q <= so_i & ~pop_o & ~used_q & (wait_q | ~last_full_i);
    end
  end

  AST_DOR_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(last_full_i) |-> $past(so_q) || $past(so_i)); // R6

endmodule

// File: rtl/bff_stage.sv
module bff_stage #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_full_i,
  input  logic             up_allow_i,
  input  logic [WIDTH-1:0] up_data_i,
  input  logic             down_take_i,
  output logic             take_o,
  output logic             full_o,
  output logic [WIDTH-1:0] data_o
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;

  assign take_o = ~full_q & up_full_i & up_allow_i;
  assign full_o = full_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          full_q <= 1'b0;
    else if (take_o)      full_q <= 1'b1;
    else if (down_take_i) full_q <= 1'b0;
  end

  // data is not reset: the output stage keeps its last word
  always_ff @(posedge clk_i) begin
    if (take_o) data_q <= up_data_i;
  end

  AST_FILL_FROM_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(up_full_i && up_allow_i)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(full_q) && !$past(down_take_i) |-> full_q && $stable(data_q)); // R5

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
  import bff_pkg::*;
#(
  parameter int unsigned WIDTH = BFF_WIDTH,
  parameter int unsigned DEPTH = BFF_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_in_i,
  input  logic             shift_out_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] data_o,
  output logic             in_ready_o,
  output logic             out_ready_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] full;
  logic [DEPTH-1:0] take;
  logic [WIDTH-1:0] word [DEPTH];
  logic             load_req, block, pop;

  bff_in_ctrl i_in_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .si_i      (shift_in_i),
    .load_i    (take[0]),
    .in_full_i (full[0]),
    .req_o     (load_req),
    .block_o   (block)
  );

  bff_out_ctrl i_out_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .so_i        (shift_out_i),
    .last_full_i (full[LAST]),
    .pop_o       (pop)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic             up_full, up_allow, down_take;
    logic [WIDTH-1:0] up_data;

    if (k == 0) begin : g_head
      assign up_full = load_req;
      assign up_data = data_i;
    end else begin : g_body
      assign up_full = full[k-1];
      assign up_data = word[k-1];
    end

    if (k == 1) begin : g_gate
      assign up_allow = ~block;
    end else begin : g_free
      assign up_allow = 1'b1;
    end

    if (k == LAST) begin : g_tail
      assign down_take = pop;
    end else begin : g_link
      assign down_take = take[k+1];
    end

    bff_stage #(.WIDTH(WIDTH)) i_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .up_full_i   (up_full),
      .up_allow_i  (up_allow),
      .up_data_i   (up_data),
      .down_take_i (down_take),
      .take_o      (take[k]),
      .full_o      (full[k]),
      .data_o      (word[k])
    );
  end

  assign in_ready_o  = ~full[0];
  assign out_ready_o = full[LAST];
  assign data_o      = oe_ni ? {WIDTH{1'bz}} : word[LAST];

  AST_DIR_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full[0]) |-> $past(shift_in_i)); // R3

endmodule

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] data_i = '0;
  logic       si = 1'b0, so = 1'b0, oe_ni = 1'b0;
  wire  [3:0] data_o;
  wire        dir, dor;

  int checks = 0, failures = 0, cycles = 0;
  logic [3:0] expq [0:63];
  int head = 0, tail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bubble_fifo i_bubble_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .shift_in_i(si),
    .shift_out_i(so), .oe_ni(oe_ni), .data_o(data_o),
    .in_ready_o(dir), .out_ready_o(dor)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] d);
    for (int i = 0; i < 64 && !dir; i++) tick();
    data_i = d; si = 1'b1; tick(); si = 1'b0; tick();
    expq[tail] = d; tail = (tail + 1) % 64;
  endtask

  task automatic pop(input bit refill);
    for (int i = 0; i < 64 && !dor; i++) tick();
    chk(dor == 1'b1, "R2", int'(dor), 1);
    chk(data_o == expq[head], "R2", int'(data_o), int'(expq[head]));
    head = (head + 1) % 64;
    so = 1'b1; tick(); so = 1'b0; tick();
    chk(dor == 1'b0, "R6", int'(dor), 0);
    if (refill) begin
      tick();
      chk(dor == 1'b1, "R6", int'(dor), 1);
    end
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] hold_word;
    int n;
    // R1: reset state
    tick(); tick(); tick();
    chk(dir == 1'b1, "R1", int'(dir), 1);
    chk(dor == 1'b0, "R1", int'(dor), 0);
    rst_ni = 1'b1; tick();

    // R2/R3: single word latency
    data_i = 4'h9; si = 1'b1; tick(); si = 1'b0;
    chk(dir == 1'b0, "R3", int'(dir), 0);
    tick();
    chk(dir == 1'b1, "R3", int'(dir), 1);
    for (int i = 0; i < 13; i++) tick();
    chk(dor == 1'b0, "R2", int'(dor), 0);
    tick();
    chk(dor == 1'b1, "R2", int'(dor), 1);
    chk(data_o == 4'h9, "R2", int'(data_o), 9);
    expq[tail] = 4'h9; tail++;

    // R10: output enable
    oe_ni = 1'b1; tick();
    chk(data_o !== 4'h9, "R10", int'(data_o), 0);
    oe_ni = 1'b0; tick();
    chk(data_o === 4'h9, "R10", int'(data_o), 9);

    // R6: read last word, empty read ignored
    pop(1'b0);
    for (int i = 0; i < 3; i++) tick();
    chk(dor == 1'b0, "R6", int'(dor), 0);
    chk(data_o == 4'h9, "R6", int'(data_o), 9);
    so = 1'b1; tick(); so = 1'b0; tick(); tick();
    chk(dor == 1'b0 && dir == 1'b1, "R6", int'(dor), 0);
    chk(data_o == 4'h9, "R6", int'(data_o), 9);

    // R4: held shift-in pins the word in stage 0
    data_i = 4'h5; si = 1'b1; tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(dir == 1'b0, "R4", int'(dir), 0);
    end
    si = 1'b0;
    for (int i = 0; i < 14; i++) tick();
    chk(dor == 1'b0, "R4", int'(dor), 0);
    tick();
    chk(dor == 1'b1, "R4", int'(dor), 1);
    expq[tail] = 4'h5; tail = (tail + 1) % 64;
    pop(1'b0);

    // R2/R3/R5/R6: full-depth rounds with distinct patterns
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) push(4'((i * (2 * r + 1) + 5 * r) & 15));
      for (int i = 0; i < 40; i++) tick();
      chk(dir == 1'b0, "R3", int'(dir), 0);
      chk(dor == 1'b1, "R3", int'(dor), 1);
      data_i = ~expq[head]; si = 1'b1; tick(); si = 1'b0; tick();
      for (int i = 0; i < 40; i++) tick();
      chk(dir == 1'b0, "R5", int'(dir), 0);
      for (int i = 0; i < 16; i++) pop(i == 0);
      for (int i = 0; i < 30; i++) tick();
      chk(dor == 1'b0, "R5", int'(dor), 0);
      chk(data_o == expq[(head + 63) % 64], "R6", int'(data_o), int'(expq[(head + 63) % 64]));
    end

    // R8: shift-in held while full
    for (int i = 0; i < 16; i++) push(4'(15 - i));
    for (int i = 0; i < 40; i++) tick();
    data_i = 4'hE; si = 1'b1; tick(); tick(); tick();
    chk(dir == 1'b0, "R8", int'(dir), 0);
    pop(1'b1);
    n = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (dir) n++; end
    chk(n == 1, "R8", n, 1);
    si = 1'b0; tick();
    expq[tail] = 4'hE; tail = (tail + 1) % 64;
    for (int i = 0; i < 30; i++) tick();
    for (int i = 0; i < 16; i++) pop(1'b0);
    for (int i = 0; i < 30; i++) tick();
    chk(dor == 1'b0, "R8", int'(dor), 0);

    // R7: shift-in high across reset release
    rst_ni = 1'b0; data_i = 4'h3; si = 1'b1; tick(); tick();
    chk(dir == 1'b1 && dor == 1'b0, "R1", int'(dir), 1);
    rst_ni = 1'b1; tick(); si = 1'b0;
    for (int i = 0; i < 40 && !dor; i++) tick();
    chk(dor == 1'b1, "R7", int'(dor), 1);
    chk(data_o == 4'h3, "R7", int'(data_o), 3);
    expq[tail] = 4'h3; tail = (tail + 1) % 64;
    pop(1'b0);

    // R1: reset keeps output word, clears contents
    push(4'hA); push(4'h6);
    for (int i = 0; i < 30; i++) tick();
    hold_word = data_o;
    chk(hold_word == 4'hA, "R2", int'(hold_word), 10);
    rst_ni = 1'b0; tick(); tick();
    chk(dir == 1'b1 && dor == 1'b0, "R1", int'(dor), 0);
    chk(data_o == 4'hA, "R1", int'(data_o), 10);
    rst_ni = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    chk(dor == 1'b0, "R1", int'(dor), 0);
    head = tail;

    // R9: shift-out held while empty
    so = 1'b1; tick();
    data_i = 4'h7; si = 1'b1; tick(); si = 1'b0;
    n = 0;
    for (int i = 0; i < 25; i++) begin tick(); if (dor) n++; end
    chk(n == 1, "R9", n, 1);
    chk(dor == 1'b0 && data_o == 4'h7, "R9", int'(data_o), 7);
    push(4'hC);
    for (int i = 0; i < 25; i++) tick();
    chk(dor == 1'b1, "R9", int'(dor), 1);
    so = 1'b0; tick(); tick(); tick();
    chk(dor == 1'b1, "R9", int'(dor), 1);
    pop(1'b0);
    chk(data_o == 4'hC, "R9", int'(data_o), 12);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule